// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block is a serial-bus master that walks an external multi-channel converter through a channel scan. A 16-bit scan mask selects the channels. Each trigger produces one manual-mode command frame per enabled channel, lowest channel first, and then two all-zero frames. The converter answers each command two frames late. The block therefore throws away the first two answers and matches every later answer to the channel that was requested for it. Each answer carries the converter's channel tag in its top nibble. The block compares that tag with the channel it expects and flags any mismatch. It extracts a right-aligned sample whose resolution is set by a parameter.

Two more operations share the same frame engine. The first is a one-shot initialisation. It writes the conversion settings and then a pin-configuration command with every option cleared. The second is a single-channel read that takes three frames. Results leave the block one at a time on a registered sample port. A one-cycle done pulse marks the end of each operation.

The serial clock comes from a plain divider. Chip select rises between every pair of 16-bit frames.

Top module: `adc_scan_seq`

## Requirements
- R1: On a trigger with a non-zero mask, the block sends one frame for each set mask bit, in ascending channel order. Each frame is 0x1000 with the channel number in bits 10:7.
- R2: The channel frames are followed by exactly two 0x0000 frames, so a scan has (set bits + 2) frames.
- R3: The answers to the first two frames of an operation are discarded. Answer k+2 produces the k-th sample, and smp_chan is the k-th requested channel.
- R4: Frames are 16 bits, most significant bit first. The serial clock idles low. mosi is stable at each rising edge, and miso is sampled on the rising edge. cs_n is high between frames and while idle, and sclk is low whenever cs_n is high.
- R5: smp_tag_err is 1 when bits 15:12 of the answer differ from the expected channel. The sample is delivered either way.
- R6: smp_value holds answer bits 11 down to 12-SAMPLE_BITS, right-aligned.
- R7: A single read of channel c sends 0x1000|c<<7 twice and then 0x0000. It yields one sample taken from the third answer.
- R8: Initialisation sends 0x1840 and then 0x4000, and produces no sample.
- R9: A trigger that arrives while busy, or together with an init or single request, starts nothing and adds no frames. overrun is high for one cycle in the next cycle.
- R10: A trigger with an all-zero mask while idle sends no frame. scan_done is high in the next cycle, with busy low.
- R11: scan_done is high for the cycle after the final frame of an operation ends. It shares that cycle with the last sample, and busy is low in it.
- R12: Requests that arrive together while idle are served in this order: init first, then single read, then trigger. The losers are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Start one scan of the masked channels |
| scan_mask | input | 16 | Channel enable mask, bit n = channel n |
| single_req | input | 1 | Start a single-channel read |
| single_chan | input | 4 | Channel for the single read |
| init_req | input | 1 | Start the initialisation sequence |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select, one low period per frame |
| mosi | output | 1 | Serial data to the converter |
| smp_valid | output | 1 | Sample fields valid this cycle |
| smp_chan | output | 4 | Channel the sample belongs to |
| smp_value | output | SAMPLE_BITS | Right-aligned sample |
| smp_tag_err | output | 1 | Returned tag disagreed with smp_chan |
| scan_done | output | 1 | One-cycle end-of-operation pulse |
| overrun | output | 1 | One-cycle pulse for a dropped trigger |
| busy | output | 1 | An operation is in progress |

## Verification
The hardest case to reach is a wrong channel tag. A correct master never causes one, so the bench's converter model has a switch that flips one tag bit in the answer for one chosen channel. The bench then scans a sparse mask that includes that channel, and also runs a single read of it. Both must deliver the sample with smp_tag_err set, and its neighbours must still arrive clean. The two-frame lag is exercised because the model answers strictly from the command seen two frames earlier. It keeps that history across operations, so an off-by-one skip count produces wrong channels. Dropped triggers are raised in the middle of a running scan, and a collision of all three requests is raised while idle.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int FRAME_W    = 16;
    localparam int CH_W       = 4;
    localparam int NUM_CH     = 1 << CH_W;
    localparam int CNT_W      = CH_W + 1;
    localparam int CMD_CH_LSB = 7;
    localparam int TAG_LSB    = FRAME_W - CH_W;

    localparam logic [FRAME_W-1:0] CMD_MANUAL   = 16'h1000;
    localparam logic [FRAME_W-1:0] CMD_WR_EN    = 16'h0800;
    localparam logic [FRAME_W-1:0] CMD_RANGE_X2 = 16'h0040;
    localparam logic [FRAME_W-1:0] CMD_PINCFG   = 16'h4000;
    localparam logic [FRAME_W-1:0] INIT_SETTINGS = CMD_MANUAL | CMD_WR_EN | CMD_RANGE_X2;

    typedef enum logic [1:0] {OP_SCAN, OP_SINGLE, OP_INIT} op_e;
    typedef enum logic [1:0] {C_IDLE, C_ISSUE, C_WAIT} ctrl_state_e;
    typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_GAP} eng_state_e;

    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            tag_err;
    } smp_hdr_t;

    function automatic logic [CH_W-1:0] lowest_chan(input logic [NUM_CH-1:0] m);
        lowest_chan = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (m[i]) lowest_chan = CH_W'(i);
        end
    endfunction

    function automatic logic [CNT_W-1:0] count_bits(input logic [NUM_CH-1:0] m);
        count_bits = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            count_bits = count_bits + CNT_W'(m[i]);
        end
    endfunction

    function automatic logic [FRAME_W-1:0] manual_cmd(input logic [CH_W-1:0] ch);
        manual_cmd = CMD_MANUAL | (FRAME_W'(ch) << CMD_CH_LSB);
    endfunction

endpackage

// File: rtl/adc_spi_frame.sv
module adc_spi_frame
    import adc_scan_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int GAP_CYC  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic               miso,
    output logic               ready,
    output logic               done,
    output logic [FRAME_W-1:0] rx_word,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi
);
    localparam int DIV_W = $clog2(HALF_DIV + 1);
    localparam int GAP_W = $clog2(GAP_CYC + 1);
    localparam int BIT_W = $clog2(FRAME_W);

    eng_state_e         state;
    logic [DIV_W-1:0]   div_cnt;
    logic [GAP_W-1:0]   gap_cnt;
    logic [BIT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] tx_sh;
    logic [FRAME_W-1:0] rx_sh;

    assign ready = (state == E_IDLE);
    assign mosi  = tx_sh[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= E_IDLE;
            div_cnt <= '0;
            gap_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_word <= '0;
            done    <= 1'b0;
            sclk    <= 1'b0;
            cs_n    <= 1'b1;
        end else begin
            done <= 1'b0;
            unique case (state)
                E_IDLE: begin
                    if (start) begin
                        tx_sh   <= tx_word;
                        cs_n    <= 1'b0;
                        sclk    <= 1'b0;
                        div_cnt <= '0;
                        bit_cnt <= '0;
                        state   <= E_SHIFT;
                    end
                end
                E_SHIFT: begin
                    if (div_cnt == DIV_W'(HALF_DIV - 1)) begin
                        div_cnt <= '0;
                        if (!sclk) begin
                            sclk  <= 1'b1;
                            rx_sh <= {rx_sh[FRAME_W-2:0], miso};
                        end else begin
                            sclk <= 1'b0;
                            if (bit_cnt == BIT_W'(FRAME_W - 1)) begin
                                cs_n    <= 1'b1;
                                done    <= 1'b1;
                                rx_word <= rx_sh;
                                gap_cnt <= '0;
                                state   <= E_GAP;
                            end else begin
                                bit_cnt <= bit_cnt + BIT_W'(1);
                                tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
                            end
                        end
                    end else begin
                        div_cnt <= div_cnt + DIV_W'(1);
                    end
                end
                E_GAP: begin
                    if (gap_cnt == GAP_W'(GAP_CYC - 1)) state <= E_IDLE;
                    else gap_cnt <= gap_cnt + GAP_W'(1);
                end
                default: state <= E_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_word_decode.sv
module adc_word_decode
    import adc_scan_pkg::*;
#(
    parameter int SAMPLE_BITS = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   emit,
    input  logic [CH_W-1:0]        exp_chan,
    input  logic [FRAME_W-1:0]     rx_word,
    output logic                   smp_valid,
    output logic [CH_W-1:0]        smp_chan,
    output logic [SAMPLE_BITS-1:0] smp_value,
    output logic                   smp_tag_err
);
    smp_hdr_t hdr_d;

    always_comb begin
        hdr_d.chan    = exp_chan;
        hdr_d.tag_err = (rx_word[FRAME_W-1:TAG_LSB] != exp_chan);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_valid   <= 1'b0;
            smp_chan    <= '0;
            smp_value   <= '0;
            smp_tag_err <= 1'b0;
        end else begin
            smp_valid <= emit;
            if (emit) begin
                smp_chan    <= hdr_d.chan;
                smp_tag_err <= hdr_d.tag_err;
                smp_value   <= rx_word[TAG_LSB-1 -: SAMPLE_BITS];
            end
        end
    end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               trig,
    input  logic [NUM_CH-1:0]  scan_mask,
    input  logic               single_req,
    input  logic [CH_W-1:0]    single_chan,
    input  logic               init_req,
    input  logic               eng_ready,
    input  logic               eng_done,
    output logic               eng_start,
    output logic [FRAME_W-1:0] eng_tx,
    output logic               emit,
    output logic [CH_W-1:0]    exp_chan,
    output logic               scan_done,
    output logic               overrun,
    output logic               busy
);
    localparam int LEFT_W = CH_W + 2;

    ctrl_state_e        state;
    op_e                op;
    logic [NUM_CH-1:0]  pend;
    logic [NUM_CH-1:0]  rxpend;
    logic [LEFT_W-1:0]  left;
    logic [1:0]         skip;
    logic [CH_W-1:0]    sgl_ch;

    logic idle, acc_init, acc_single, acc_scan, drop_trig;

    assign idle       = (state == C_IDLE);
    assign busy       = !idle;
    assign acc_init   = idle && init_req;
    assign acc_single = idle && single_req && !init_req;
    assign acc_scan   = idle && trig && !init_req && !single_req;
    assign drop_trig  = trig && !acc_scan;

    assign eng_start = (state == C_ISSUE) && eng_ready;
    assign exp_chan  = lowest_chan(rxpend);
    assign emit      = (state == C_WAIT) && eng_done && (skip == 2'd0) && (rxpend != '0);

    always_comb begin
        unique case (op)
            OP_INIT:   eng_tx = (left == LEFT_W'(2)) ? INIT_SETTINGS : CMD_PINCFG;
            OP_SINGLE: eng_tx = (left > LEFT_W'(1)) ? manual_cmd(sgl_ch) : '0;
            default:   eng_tx = (pend != '0) ? manual_cmd(lowest_chan(pend)) : '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= C_IDLE;
            op        <= OP_SCAN;
            pend      <= '0;
            rxpend    <= '0;
            left      <= '0;
            skip      <= '0;
            sgl_ch    <= '0;
            scan_done <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            scan_done <= 1'b0;
            overrun   <= drop_trig;
            unique case (state)
                C_IDLE: begin
                    if (acc_init) begin
                        op     <= OP_INIT;
                        left   <= LEFT_W'(2);
                        rxpend <= '0;
                        skip   <= 2'd2;
                        state  <= C_ISSUE;
                    end else if (acc_single) begin
                        op     <= OP_SINGLE;
                        sgl_ch <= single_chan;
                        rxpend <= NUM_CH'(1) << single_chan;
                        left   <= LEFT_W'(3);
                        skip   <= 2'd2;
                        state  <= C_ISSUE;
                    end else if (acc_scan) begin
                        if (scan_mask == '0) begin
                            scan_done <= 1'b1;
                        end else begin
                            op     <= OP_SCAN;
                            pend   <= scan_mask;
                            rxpend <= scan_mask;
                            left   <= LEFT_W'(count_bits(scan_mask)) + LEFT_W'(2);
                            skip   <= 2'd2;
                            state  <= C_ISSUE;
                        end
                    end
                end
                C_ISSUE: begin
                    if (eng_ready) begin
                        if (op == OP_SCAN && pend != '0)
                            pend <= pend & ~(NUM_CH'(1) << lowest_chan(pend));
                        state <= C_WAIT;
                    end
                end
                C_WAIT: begin
                    if (eng_done) begin
                        left <= left - LEFT_W'(1);
                        if (skip != 2'd0)
                            skip <= skip - 2'd1;
                        else if (rxpend != '0)
                            rxpend <= rxpend & ~(NUM_CH'(1) << exp_chan);
                        if (left == LEFT_W'(1)) begin
                            state     <= C_IDLE;
                            scan_done <= 1'b1;
                        end else begin
                            state <= C_ISSUE;
                        end
                    end
                end
                default: state <= C_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int HALF_DIV    = 2,
    parameter int GAP_CYC     = 2,
    parameter int SAMPLE_BITS = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   trig,
    input  logic [15:0]            scan_mask,
    input  logic                   single_req,
    input  logic [3:0]             single_chan,
    input  logic                   init_req,
    input  logic                   miso,
    output logic                   sclk,
    output logic                   cs_n,
    output logic                   mosi,
    output logic                   smp_valid,
    output logic [3:0]             smp_chan,
    output logic [SAMPLE_BITS-1:0] smp_value,
    output logic                   smp_tag_err,
    output logic                   scan_done,
    output logic                   overrun,
    output logic                   busy
);
    logic               eng_start, eng_ready, eng_done, emit;
    logic [FRAME_W-1:0] eng_tx, eng_rx;
    logic [CH_W-1:0]    exp_chan;

    adc_scan_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .trig       (trig),
        .scan_mask  (scan_mask),
        .single_req (single_req),
        .single_chan(single_chan),
        .init_req   (init_req),
        .eng_ready  (eng_ready),
        .eng_done   (eng_done),
        .eng_start  (eng_start),
        .eng_tx     (eng_tx),
        .emit       (emit),
        .exp_chan   (exp_chan),
        .scan_done  (scan_done),
        .overrun    (overrun),
        .busy       (busy)
    );

    adc_spi_frame #(.HALF_DIV(HALF_DIV), .GAP_CYC(GAP_CYC)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .start  (eng_start),
        .tx_word(eng_tx),
        .miso   (miso),
        .ready  (eng_ready),
        .done   (eng_done),
        .rx_word(eng_rx),
        .sclk   (sclk),
        .cs_n   (cs_n),
        .mosi   (mosi)
    );

    adc_word_decode #(.SAMPLE_BITS(SAMPLE_BITS)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .emit       (emit),
        .exp_chan   (exp_chan),
        .rx_word    (eng_rx),
        .smp_valid  (smp_valid),
        .smp_chan   (smp_chan),
        .smp_value  (smp_value),
        .smp_tag_err(smp_tag_err)
    );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        trig,
    input logic [15:0] scan_mask,
    input logic        single_req,
    input logic        init_req,
    input logic        sclk,
    input logic        cs_n,
    input logic        smp_valid,
    input logic        scan_done,
    input logic        overrun,
    input logic        busy
);
    a_r4_cs_high_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n);

    a_r4_sclk_low_deselected: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    a_r9_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(trig));

    a_r9_busy_trigger_flagged: assert property (@(posedge clk) disable iff (rst)
        (trig && busy) |=> overrun);

    a_r10_empty_mask_done: assert property (@(posedge clk) disable iff (rst)
        (trig && !busy && !init_req && !single_req && scan_mask == 16'h0) |=> scan_done);

    a_r11_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        scan_done |-> !busy);

    a_r3_sample_between_frames: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> cs_n);
endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .trig      (trig),
    .scan_mask (scan_mask),
    .single_req(single_req),
    .init_req  (init_req),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .smp_valid (smp_valid),
    .scan_done (scan_done),
    .overrun   (overrun),
    .busy      (busy)
);

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
    localparam int N = 10;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst, trig, single_req, init_req, miso;
    logic [15:0] scan_mask;
    logic [3:0]  single_chan;
    logic        sclk, cs_n, mosi, smp_valid, smp_tag_err, scan_done, overrun, busy;
    logic [3:0]  smp_chan;
    logic [N-1:0] smp_value;

    adc_scan_seq #(.HALF_DIV(2), .GAP_CYC(2), .SAMPLE_BITS(N)) uut (
        .clk(clk), .rst(rst), .trig(trig), .scan_mask(scan_mask),
        .single_req(single_req), .single_chan(single_chan), .init_req(init_req),
        .miso(miso), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_value(smp_value),
        .smp_tag_err(smp_tag_err), .scan_done(scan_done), .overrun(overrun), .busy(busy)
    );

    int checks = 0, fails = 0, cyc = 0, done_cnt = 0, done_cyc = -1, last_smp = -2;
    int smp_cnt = 0, idle_err = 0;

    logic [11:0] salt = 12'h35A;
    logic        bad_en = 1'b0;
    logic [3:0]  bad_ch = 4'd0;
    logic [15:0] hist1 = 16'h0, hist2 = 16'h0;

    logic [15:0] xf_q[$];
    string       xf_tag[$];
    int          xs_ch[$];
    int          xs_val[$];
    bit          xs_err[$];
    string       xs_tag[$];

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] data12(logic [3:0] ch);
        return (12'(ch) * 12'h111) ^ salt;
    endfunction

    function automatic logic [15:0] mk_resp(logic [15:0] cmd);
        logic [3:0] ch, tag;
        ch  = cmd[10:7];
        tag = (bad_en && ch == bad_ch) ? (ch ^ 4'h1) : ch;
        return {tag, data12(ch)};
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Converter model: answers with the command seen two frames earlier.
    initial begin
        miso = 1'b0;
        forever begin
            logic [15:0] resp, rx, e;
            string t;
            @(negedge cs_n);
            resp = mk_resp(hist2);
            miso = resp[15];
            rx = 16'h0;
            for (int b = 0; b < 16; b++) begin
                @(posedge sclk);
                rx = {rx[14:0], mosi};
                if (b < 15) begin
                    @(negedge sclk);
                    miso = resp[14-b];
                end
            end
            @(posedge cs_n);
            hist2 = hist1;
            hist1 = rx;
            if (xf_q.size() == 0) begin
                check(1'b0, "R9", "unexpected frame", int'(rx), 0);
            end else begin
                e = xf_q.pop_front();
                t = xf_tag.pop_front();
                check(rx == e, t, "frame word", int'(rx), int'(e));
            end
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (cs_n && sclk) idle_err++;
            if (smp_valid) begin
                smp_cnt++;
                last_smp = cyc;
                if (xs_ch.size() == 0) begin
                    check(1'b0, "R3", "unexpected sample", int'(smp_chan), 0);
                end else begin
                    int ec, ev; bit ee; string t;
                    ec = xs_ch.pop_front(); ev = xs_val.pop_front();
                    ee = xs_err.pop_front(); t = xs_tag.pop_front();
                    check(int'(smp_chan) == ec, t, "sample channel", int'(smp_chan), ec);
                    check(int'(smp_value) == ev, "R6", "sample value", int'(smp_value), ev);
                    check(smp_tag_err == ee, "R5", "tag error flag", int'(smp_tag_err), int'(ee));
                end
            end
            if (scan_done) begin
                done_cnt++;
                done_cyc = cyc;
                check(!busy, "R11", "busy during done", int'(busy), 0);
            end
        end
    end

    task automatic push_frame(logic [15:0] w, string t);
        xf_q.push_back(w);
        xf_tag.push_back(t);
    endtask

    task automatic push_smp(int ch, string t);
        xs_ch.push_back(ch);
        xs_val.push_back(int'(data12(4'(ch)) >> (12 - N)));
        xs_err.push_back(bad_en && 4'(ch) == bad_ch);
        xs_tag.push_back(t);
    endtask

    task automatic wait_done(string t);
        int s, n;
        s = done_cnt;
        n = 0;
        while (done_cnt == s && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(done_cnt != s, t, "done pulse seen", done_cnt - s, 1);
        @(negedge clk);
    endtask

    task automatic finish_op(string t, bit expect_smp);
        check(xf_q.size() == 0, "R2", "frames outstanding", xf_q.size(), 0);
        check(xs_ch.size() == 0, "R3", "samples outstanding", xs_ch.size(), 0);
        if (expect_smp)
            check(last_smp == done_cyc, t, "last sample cycle vs done", last_smp, done_cyc);
    endtask

    task automatic push_scan(logic [15:0] m);
        for (int ch = 0; ch < 16; ch++)
            if (m[ch]) push_frame(16'h1000 | (16'(ch) << 7), "R1");
        push_frame(16'h0000, "R2");
        push_frame(16'h0000, "R2");
        for (int ch = 0; ch < 16; ch++)
            if (m[ch]) push_smp(ch, "R3");
    endtask

    task automatic run_scan(logic [15:0] m);
        push_scan(m);
        scan_mask = m;
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        wait_done("R11");
        finish_op("R11", 1'b1);
    endtask

    task automatic run_single(logic [3:0] ch);
        push_frame(16'h1000 | (16'(ch) << 7), "R7");
        push_frame(16'h1000 | (16'(ch) << 7), "R7");
        push_frame(16'h0000, "R7");
        push_smp(int'(ch), "R7");
        single_chan = ch;
        @(negedge clk) single_req = 1'b1;
        @(negedge clk) single_req = 1'b0;
        wait_done("R7");
        finish_op("R7", 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int s;
        rst = 1'b1; trig = 1'b0; single_req = 1'b0; init_req = 1'b0;
        scan_mask = 16'h0; single_chan = 4'h0;
        repeat (5) @(negedge clk);
        // R4 / R11 reset state
        check(cs_n == 1'b1, "R4", "cs_n in reset", int'(cs_n), 1);
        check(sclk == 1'b0, "R4", "sclk in reset", int'(sclk), 0);
        check(busy == 1'b0, "R11", "busy in reset", int'(busy), 0);
        check(smp_valid == 1'b0 && scan_done == 1'b0, "R11", "pulses in reset",
              int'({smp_valid, scan_done}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R8 initialisation
        s = smp_cnt;
        push_frame(16'h1840, "R8");
        push_frame(16'h4000, "R8");
        @(negedge clk) init_req = 1'b1;
        @(negedge clk) init_req = 1'b0;
        wait_done("R8");
        finish_op("R8", 1'b0);
        check(smp_cnt == s, "R8", "samples from init", smp_cnt - s, 0);

        // R1 R2 R3 R6 scans with several masks
        run_scan(16'h0001);
        salt = 12'hC93;
        run_scan(16'h8421);
        salt = 12'h5E7;
        run_scan(16'hFFFF);

        // R5 corrupted tag on channel 7
        bad_en = 1'b1; bad_ch = 4'd7;
        run_scan(16'hA5A0);
        run_single(4'd7);
        bad_en = 1'b0;
        run_single(4'd9);
        run_single(4'd0);

        // R10 empty mask
        s = done_cnt;
        scan_mask = 16'h0;
        @(negedge clk) trig = 1'b1;
        @(negedge clk);
        check(scan_done == 1'b1, "R10", "done after empty trigger", int'(scan_done), 1);
        check(busy == 1'b0, "R10", "busy after empty trigger", int'(busy), 0);
        trig = 1'b0;
        repeat (200) @(negedge clk);
        check(cs_n == 1'b1 && busy == 1'b0, "R10", "still idle", int'({cs_n, busy}), 2);

        // R9 trigger while busy
        push_scan(16'h0003);
        scan_mask = 16'h0003;
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        repeat (20) @(negedge clk);
        check(busy == 1'b1, "R9", "busy mid scan", int'(busy), 1);
        scan_mask = 16'h00F0;
        trig = 1'b1;
        @(negedge clk);
        check(overrun == 1'b1, "R9", "overrun pulse", int'(overrun), 1);
        trig = 1'b0;
        @(negedge clk);
        check(overrun == 1'b0, "R9", "overrun one cycle", int'(overrun), 0);
        wait_done("R9");
        finish_op("R9", 1'b1);
        repeat (200) @(negedge clk);
        check(busy == 1'b0, "R9", "dropped trigger started nothing", int'(busy), 0);

        // R12 simultaneous requests: init wins, single and trigger dropped
        s = smp_cnt;
        push_frame(16'h1840, "R12");
        push_frame(16'h4000, "R12");
        scan_mask = 16'h0010;
        single_chan = 4'd3;
        @(negedge clk) begin init_req = 1'b1; single_req = 1'b1; trig = 1'b1; end
        @(negedge clk);
        check(overrun == 1'b1, "R12", "trigger lost to init", int'(overrun), 1);
        init_req = 1'b0; single_req = 1'b0; trig = 1'b0;
        wait_done("R12");
        repeat (200) @(negedge clk);
        finish_op("R12", 1'b0);
        check(smp_cnt == s, "R12", "no sample from dropped single", smp_cnt - s, 0);

        // R4 line levels over the whole run
        check(idle_err == 0, "R4", "sclk high while deselected", idle_err, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule